// File: doc/BRIEF.md
# Clock Ratio Transition Sequencer

This block steers a core clock divider that can run at 1, 2, 4, 6 or 8 times the base period. A requester asks for a new ratio index. The sequencer then walks the divider to that ratio one hop at a time. Within each hop it orders three actions by the direction of the change: the memory self-refresh enable, the divider select, and the DRAM refresh-count update. After a divider write it waits a fixed number of cycles so the PLL can lock. When it slows down while self-refresh is off, it also waits for the old and the new refresh periods to drain.

The request side is a valid/ready channel. The requester raises `req_valid` with `req_index` and must hold both until it sees `req_ready` high at a clock edge; that edge is the acceptance. `req_ready` is low for the whole time a transition is in progress, which back-pressures any new request. Completion is reported by a one-cycle `done` pulse. A rejected index is reported by a one-cycle `bad_index` pulse. `busy`, `div_sel`, `self_refresh` and the refresh-count strobe are plain level or pulse signals.

The refresh count for a ratio is `BASE_RCNT` divided by that ratio's divisor, using integer division. The drain wait is `CLKS_PER_CNT` × (old count + new count) × old divisor cycles.

Top module: `clk_ratio_seq`

## Requirements
- R1: Ratio index 0,1,2,3,4 selects divisor 1,2,4,6,8. `div_sel` carries 3'b000, 3'b001, 3'b011, 3'b010, 3'b100 for those divisors. `rcnt_val` carries `BASE_RCNT`/divisor for the ratio last reached.
- R2: Moving from divisor 2 to divisor 1 clears `self_refresh`, then writes `div_sel`, then pulses `rcnt_upd` with the new count.
- R3: Moving from divisor 1 to divisor 2 pulses `rcnt_upd` first, waits for the drain, then writes `div_sel`, then sets `self_refresh`.
- R4: A change from divisor 1 to divisor 4, 6 or 8, or from one of those to divisor 1, takes two hops, and the first hop lands on divisor 2. `div_sel` never moves directly between 3'b000 and 3'b011, 3'b010 or 3'b100.
- R5: Between two divisors that are both 2 or more, a move to a larger divisor pulses `rcnt_upd` before writing `div_sel`. A move to a smaller divisor writes `div_sel` first and then pulses `rcnt_upd`. `self_refresh` does not change in either case.
- R6: After every `div_sel` change, at least `LOCK_CYC` (16) cycles pass before the next step of the sequence becomes visible.
- R7: When the divisor grows while `self_refresh` is low, at least `CLKS_PER_CNT`×(old count + new count)×old divisor cycles pass between the `rcnt_upd` pulse and the `div_sel` change.
- R8: A request for the ratio already in use changes no output. It pulses `done` in the cycle after acceptance, and `busy` stays low.
- R9: A request for index 5, 6 or 7 pulses `bad_index` for one cycle in the cycle after acceptance. It leaves `div_sel` unchanged, does not pulse `done`, and keeps `busy` low.
- R10: `req_ready` is the inverse of `busy`. `busy` rises in the cycle after an accepted change and falls in the same cycle as the one-cycle `done` pulse. Requests offered while busy are not taken and have no effect.
- R11: After reset, `div_sel` is 3'b000, `self_refresh` is 0, `busy` is 0, `rcnt_val` equals `BASE_RCNT` and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Ratio request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_index | input | 3 | Requested ratio index |
| done | output | 1 | One-cycle pulse when a request completes |
| bad_index | output | 1 | One-cycle pulse for an index above 4 |
| busy | output | 1 | Transition in progress |
| div_sel | output | 3 | Divider select code |
| self_refresh | output | 1 | Memory self-refresh enable |
| rcnt_upd | output | 1 | One-cycle strobe to load a new refresh count |
| rcnt_val | output | RCNT_W | Refresh count for the current ratio |

## Verification
A wrong stored ratio shows up at the next request. The sequencer then plans the wrong hops, so `div_sel`, `self_refresh` or `rcnt_upd` produce an event that is missing, extra or out of order; the monitor sees this at the first step, within a few cycles of acceptance. A timer that stops early shows as a gap between two events that is shorter than the lock or drain window, so it is caught at the event that ends that window. A wrong state after the last hop shows as `done` coming late or never, or as `busy` and `done` disagreeing in that same cycle.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef logic [2:0] idx_t;
  typedef logic [2:0] sel_t;

  localparam int unsigned NUM_RATIOS = 5;
  localparam int unsigned MAX_DIV    = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOP,
    ST_SR_CLR,
    ST_RC_UP,
    ST_DRAIN,
    ST_DIV,
    ST_LOCK,
    ST_RC_DN,
    ST_SR_SET,
    ST_NEXT
  } seq_st_e;

  function automatic sel_t ratio_code(idx_t i);
    case (i)
      3'd0:    return 3'b000;
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      3'd4:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [3:0] ratio_div(idx_t i);
    case (i)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/crs_timer.sv
module crs_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // Timer must count down by one per cycle while it is running (R6, R7)
  assert_timer_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/crs_route.sv
module crs_route
  import crs_pkg::*;
#(
  parameter int unsigned RCNT_W       = 7,
  parameter int unsigned BASE_RCNT    = 48,
  parameter int unsigned CLKS_PER_CNT = 64,
  parameter int unsigned TMR_W        = 17
) (
  input  idx_t              cur_idx,
  input  idx_t              tgt_idx,
  input  logic              sref_on,
  output idx_t              hop_idx,
  output logic              hop_up,
  output logic              drain_need,
  output logic [TMR_W-1:0]  drain_cyc,
  output logic [RCNT_W-1:0] hop_cnt
);

  function automatic int unsigned cnt_of(idx_t i);
    return BASE_RCNT / 32'(ratio_div(i));
  endfunction

  int unsigned cur_cnt_i;
  int unsigned new_cnt_i;
  int unsigned drain_i;
  logic        cross_one;

  always_comb begin
    // Any move between divisor 1 and a divisor above 2 must stop at divisor 2
    cross_one = ((cur_idx == 3'd0) && (tgt_idx >= 3'd2)) ||
                ((cur_idx >= 3'd2) && (tgt_idx == 3'd0));
    hop_idx   = cross_one ? 3'd1 : tgt_idx;
    hop_up    = ratio_div(hop_idx) > ratio_div(cur_idx);
    cur_cnt_i = cnt_of(cur_idx);
    new_cnt_i = cnt_of(hop_idx);
    drain_i   = CLKS_PER_CNT * (cur_cnt_i + new_cnt_i) * 32'(ratio_div(cur_idx));
    drain_need = hop_up && !sref_on;
    drain_cyc  = TMR_W'(drain_i);
    hop_cnt    = RCNT_W'(new_cnt_i);
  end

endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
  import crs_pkg::*;
#(
  parameter int unsigned RCNT_W       = 7,
  parameter int unsigned BASE_RCNT    = 48,
  parameter int unsigned CLKS_PER_CNT = 64,
  parameter int unsigned LOCK_CYC     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_index,
  output logic              done,
  output logic              bad_index,
  output logic              busy,
  output logic [2:0]        div_sel,
  output logic              self_refresh,
  output logic              rcnt_upd,
  output logic [RCNT_W-1:0] rcnt_val
);

  localparam int unsigned DRAIN_MAX = CLKS_PER_CNT * 2 * ((1 << RCNT_W) - 1) * MAX_DIV;
  localparam int unsigned TMR_W     = $clog2(DRAIN_MAX + 1);

  seq_st_e           state_q;
  idx_t              cur_q, tgt_q, hop_q, old_q;
  logic              up_q, drain_need_q;
  logic [TMR_W-1:0]  drain_q;
  logic [RCNT_W-1:0] hop_cnt_q;
  logic              done_q, bad_q, upd_q, sref_q;
  sel_t              sel_q;
  logic [RCNT_W-1:0] cnt_q;

  idx_t              r_hop;
  logic              r_up, r_drain;
  logic [TMR_W-1:0]  r_drain_cyc;
  logic [RCNT_W-1:0] r_cnt;

  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;

  crs_route #(
    .RCNT_W(RCNT_W), .BASE_RCNT(BASE_RCNT),
    .CLKS_PER_CNT(CLKS_PER_CNT), .TMR_W(TMR_W)
  ) route_i (
    .cur_idx(cur_q), .tgt_idx(tgt_q), .sref_on(sref_q),
    .hop_idx(r_hop), .hop_up(r_up), .drain_need(r_drain),
    .drain_cyc(r_drain_cyc), .hop_cnt(r_cnt)
  );

  always_comb begin
    tmr_load = (state_q == ST_DIV) || ((state_q == ST_RC_UP) && drain_need_q);
    tmr_val  = (state_q == ST_DIV) ? TMR_W'(LOCK_CYC) : drain_q;
  end

  crs_timer #(.W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_q        <= '0;
      tgt_q        <= '0;
      hop_q        <= '0;
      old_q        <= '0;
      up_q         <= 1'b0;
      drain_need_q <= 1'b0;
      drain_q      <= '0;
      hop_cnt_q    <= '0;
      done_q       <= 1'b0;
      bad_q        <= 1'b0;
      upd_q        <= 1'b0;
      sref_q       <= 1'b0;
      sel_q        <= 3'b000;
      cnt_q        <= RCNT_W'(BASE_RCNT);
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      upd_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          if (req_index > 3'd4)        bad_q  <= 1'b1;
          else if (req_index == cur_q) done_q <= 1'b1;
          else begin
            tgt_q   <= req_index;
            state_q <= ST_HOP;
          end
        end
        ST_HOP: begin
          hop_q        <= r_hop;
          up_q         <= r_up;
          drain_need_q <= r_drain;
          drain_q      <= r_drain_cyc;
          hop_cnt_q    <= r_cnt;
          if (r_up)               state_q <= ST_RC_UP;
          else if (r_hop == 3'd0) state_q <= ST_SR_CLR;
          else                    state_q <= ST_DIV;
        end
        ST_SR_CLR: begin
          sref_q  <= 1'b0;
          state_q <= ST_DIV;
        end
        ST_RC_UP: begin
          upd_q   <= 1'b1;
          cnt_q   <= hop_cnt_q;
          state_q <= drain_need_q ? ST_DRAIN : ST_DIV;
        end
        ST_DRAIN: if (tmr_exp) state_q <= ST_DIV;
        ST_DIV: begin
          sel_q   <= ratio_code(hop_q);
          old_q   <= cur_q;
          cur_q   <= hop_q;
          state_q <= ST_LOCK;
        end
        ST_LOCK: if (tmr_exp) begin
          if (!up_q)              state_q <= ST_RC_DN;
          else if (old_q == 3'd0) state_q <= ST_SR_SET;
          else                    state_q <= ST_NEXT;
        end
        ST_RC_DN: begin
          upd_q   <= 1'b1;
          cnt_q   <= hop_cnt_q;
          state_q <= ST_NEXT;
        end
        ST_SR_SET: begin
          sref_q  <= 1'b1;
          state_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (cur_q == tgt_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_HOP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign bad_index    = bad_q;
  assign div_sel      = sel_q;
  assign self_refresh = sref_q;
  assign rcnt_upd     = upd_q;
  assign rcnt_val     = cnt_q;

  // R1: only the five legal select codes ever appear
  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_sel inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});

  // R2: entering divide-by-1 happens only with self-refresh already off
  assert_sref_off_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_sel) && div_sel == 3'b000) |-> !self_refresh);

  // R3: self-refresh turns on only at divide-by-2
  assert_sref_on_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_refresh) |-> (div_sel == 3'b001));

  // R4: no direct jump between divide-by-1 and the deep ratios
  assert_no_jump_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_sel) && $past(div_sel) == 3'b000) |-> (div_sel == 3'b001));
  assert_no_jump_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_sel) && div_sel == 3'b000) |-> ($past(div_sel) == 3'b001));

  // R6: a divider write is followed by a held, busy cycle
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |=> (busy && $stable(div_sel) && !rcnt_upd && $stable(self_refresh)));

  // R8: same-ratio request completes at once with no activity
  assert_same_ratio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_index == cur_q) |=> (done && !busy && $stable(div_sel)));

  // R9: an index above 4 is rejected and nothing moves
  assert_bad_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_index > 3'd4) |=> (bad_index && !done && !busy && $stable(div_sel)));

  // R10: done is a single-cycle pulse and ends the busy window
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/clk_ratio_seq_tb_top.sv
module clk_ratio_seq_tb_top;

  localparam int BASE = 48;
  localparam int CPC  = 64;
  localparam int LOCK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_index = 3'd0;
  logic       req_ready, done, bad_index, busy, self_refresh, rcnt_upd;
  logic [2:0] div_sel;
  logic [6:0] rcnt_val;

  always #4 clk = ~clk;

  clk_ratio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .done(done), .bad_index(bad_index), .busy(busy),
    .div_sel(div_sel), .self_refresh(self_refresh), .rcnt_upd(rcnt_upd),
    .rcnt_val(rcnt_val)
  );

  typedef struct {
    int    kind;   // 0 self_refresh, 1 div_sel, 2 rcnt_upd
    int    val;
    int    gap;
    string tag;
    string gtag;
  } evt_t;

  evt_t expq[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   m_cur   = 0;
  int   m_sref  = 0;
  int   pend    = 0;
  string pend_tag = "R6";
  int   cyc = 0;
  int   last_cyc = 0;
  logic [2:0] prv_div;
  logic       prv_sref;

  function automatic int enc(int i);
    case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
  endfunction
  function automatic int dv(int i);
    case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
  endfunction
  function automatic int cnt(int i);
    return BASE / dv(i);
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int val, input string tag);
    evt_t e;
    e.kind = kind; e.val = val; e.gap = pend; e.tag = tag; e.gtag = pend_tag;
    expq.push_back(e);
    pend = 0; pend_tag = "R6";
  endtask

  task automatic plan_hop(input int o, input int n, input string tag);
    if (dv(n) > dv(o)) begin
      push(2, cnt(n), tag);
      if (m_sref == 0) begin
        pend = CPC * (cnt(o) + cnt(n)) * dv(o);
        pend_tag = "R7";
      end
      push(1, enc(n), tag);
      pend = LOCK;
      if (o == 0) begin
        push(0, 1, tag);
        m_sref = 1;
      end
    end else begin
      if (n == 0) begin
        push(0, 0, tag);
        m_sref = 0;
      end
      push(1, enc(n), tag);
      pend = LOCK;
      push(2, cnt(n), tag);
    end
  endtask

  // Monitor: compare observed events with the scoreboard queue
  task automatic got(input int kind, input int val);
    evt_t e;
    if (expq.size() == 0) begin
      check(1'b0, "R10", $sformatf("unexpected event kind %0d", kind), val, -1);
    end else begin
      e = expq.pop_front();
      check(e.kind == kind, e.tag, "event kind", kind, e.kind);
      check(e.val == val, e.tag, "event value", val, e.val);
      check((cyc - last_cyc) >= e.gap, e.gtag, "gap before event", cyc - last_cyc, e.gap);
    end
    last_cyc = cyc;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prv_div  <= 3'b000;
      prv_sref <= 1'b0;
    end else begin
      cyc++;
      if (rcnt_upd)                 got(2, int'(rcnt_val));
      if (div_sel != prv_div)       got(1, int'(div_sel));
      if (self_refresh != prv_sref) got(0, int'(self_refresh));
      prv_div  <= div_sel;
      prv_sref <= self_refresh;
    end
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      n_tests++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic request(input int idx, input bit poke);
    int n;
    string tag;
    if (idx <= 4 && idx != m_cur) begin
      if ((m_cur == 0 && idx >= 2) || (m_cur >= 2 && idx == 0)) begin
        plan_hop(m_cur, 1, "R4");
        plan_hop(1, idx, "R4");
      end else begin
        tag = (m_cur == 0 && idx == 1) ? "R3" : (m_cur == 1 && idx == 0) ? "R2" : "R5";
        plan_hop(m_cur, idx, tag);
      end
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_index = 3'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    if (idx > 4) begin
      check(bad_index && !busy && !done, "R9", "reject pulse", int'({bad_index, busy, done}), 4);
      @(negedge clk);
      check(!bad_index, "R9", "reject pulse width", int'(bad_index), 0);
      check(int'(div_sel) == enc(m_cur), "R9", "divider unchanged", int'(div_sel), enc(m_cur));
    end else if (idx == m_cur) begin
      check(done && !busy, "R8", "same-ratio done", int'({done, busy}), 2);
      @(negedge clk);
      check(!done && !busy, "R8", "same-ratio quiet", int'({done, busy}), 0);
      check(int'(div_sel) == enc(m_cur), "R8", "divider unchanged", int'(div_sel), enc(m_cur));
    end else begin
      check(busy && !req_ready, "R10", "busy after accept", int'({busy, req_ready}), 2);
      n = 0;
      while (!done && n < 100000) begin
        if (poke && n == 3) begin
          req_valid = 1'b1;
          req_index = 3'd4;
        end
        if (poke && n == 4)
          check(!req_ready, "R10", "ready low while busy", int'(req_ready), 0);
        if (poke && n == 10) req_valid = 1'b0;
        @(negedge clk);
        n++;
      end
      check(done && !busy, "R10", "done with busy low", int'({done, busy}), 2);
      check(expq.size() == 0, "R4", "pending expected events", expq.size(), 0);
      check(int'(div_sel) == enc(idx), "R1", "final divider code", int'(div_sel), enc(idx));
      check(int'(rcnt_val) == cnt(idx), "R1", "final refresh count", int'(rcnt_val), cnt(idx));
      @(negedge clk);
      check(!done, "R10", "done pulse width", int'(done), 0);
      m_cur = idx;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(div_sel == 3'b000, "R11", "reset div_sel", int'(div_sel), 0);
    check(!self_refresh, "R11", "reset self_refresh", int'(self_refresh), 0);
    check(!busy && req_ready, "R11", "reset idle", int'({busy, req_ready}), 1);
    check(!done && !bad_index && !rcnt_upd, "R11", "reset pulses", int'({done, bad_index, rcnt_upd}), 0);
    check(int'(rcnt_val) == BASE, "R11", "reset refresh count", int'(rcnt_val), BASE);

    request(1, 1'b0);   // R3 divisor 1 -> 2 with drain
    request(1, 1'b0);   // R8 same ratio
    request(2, 1'b0);   // R5 up 2 -> 4
    request(4, 1'b0);   // R5 up 4 -> 8
    request(3, 1'b0);   // R5 down 8 -> 6
    request(0, 1'b0);   // R4 6 -> 2 -> 1, R2 final hop
    request(6, 1'b0);   // R9 reject
    request(3, 1'b1);   // R4 1 -> 2 -> 6, R10 request while busy
    request(7, 1'b0);   // R9 reject
    request(0, 1'b0);   // R4 back to 1
    request(5, 1'b0);   // R9 reject at divisor 1
    request(1, 1'b0);   // R3 again
    request(0, 1'b0);   // R2 single hop

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R10", "leftover events", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule